// File: doc/BRIEF.md
# Frequency-Comparison Lock Detector

This block watches a clock-recovery loop and decides whether the loop is locked to the incoming data. It runs a measurement window of a fixed number of reference-clock cycles. Over each window it counts cycles of the recovered clock and compares the count with the window length times a ratio picked by a 2-bit select. When the count is within about 1000 ppm of that target, the window is judged good.

One bad window is enough to withdraw lock. The block then steers the recovery loop to train on the reference-derived frequency. It keeps measuring, and it grants lock again only after a run of consecutive good windows. A carrier-detect level overrides all of this. While carrier is absent, the incoming data is gated low, the indicator is held low and the loop is kept on the reference. A reset or a change of the ratio select throws away the window in progress and starts measuring afresh.

Top module: `freq_lock_monitor`

## Requirements
- R1: The ratio select maps to a recovered-to-reference frequency ratio as follows: 2'b00 gives 8, 2'b01 gives 10, 2'b10 gives 16 and 2'b11 gives 20. A recovered clock at exactly the selected ratio reaches lock. A recovered clock at the ratio of a different code does not.
- R2: A window lasts 2^WIN_LOG2 reference cycles. A window is good when the measured recovered-clock count differs from the window length times the ratio by no more than that product divided by 1024 (about 977 ppm). Offsets of 500 ppm lock, and offsets of 3000 ppm do not.
- R3: A single window outside the band clears link_ok no later than a few cycles after the end of the window that follows the frequency step.
- R4: While unlocked, measuring continues. link_ok rises only after GOOD_WINDOWS (default 2) consecutive good windows that both started after the last restart. After a restart it is therefore still low 2^(WIN_LOG2+1)-3 cycles later.
- R5: train_on_ref is high exactly when link_ok is low.
- R6: While carrier_ok is low, link_ok is low, train_on_ref is high and data_gate_low is high, in the same cycle. While carrier_ok is high, data_gate_low is low.
- R7: After carrier_ok returns high, link_ok stays low until GOOD_WINDOWS good window results have been reported, and then it rises.
- R8: During reset, link_ok is low and train_on_ref is high.
- R9: A change of ratio_sel clears lock on the next reference edge and restarts the window timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| rec_clk | input | 1 | Recovered clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| carrier_ok | input | 1 | Carrier-detect level; high means a signal is present |
| ratio_sel | input | 2 | Ratio select, synchronous to ref_clk |
| link_ok | output | 1 | Lock / link-good indicator, active high |
| train_on_ref | output | 1 | High: the recovery loop trains on the reference |
| data_gate_low | output | 1 | High: the incoming serial data is forced low |

## Verification
A wrong measurement path, a wrong ratio decode or a wrong band width shows at link_ok within two windows of a restart. The indicator then either comes up for a frequency that is out of band or stays down for one that is in band. A corrupted streak count or a missing discard of the first partial window shows up as lock arriving one window early. A missed bad-window check shows up as lock surviving a large frequency step for more than two windows. The carrier override is visible at the outputs in the very cycle it changes.

// File: rtl/flm_pkg.sv
`timescale 1ns/1fs
package flm_pkg;

   typedef enum logic {
      ST_TRAIN = 1'b0,
      ST_LOCK  = 1'b1
   } lock_state_e;

   localparam int RATIO_W   = 5;
   localparam int TOL_SHIFT = 10;

   function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] sel);
      logic [RATIO_W-1:0] r;
      case (sel)
         2'b00:   r = 5'd8;
         2'b01:   r = 5'd10;
         2'b10:   r = 5'd16;
         default: r = 5'd20;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/flm_window_timer.sv
`timescale 1ns/1fs
module flm_window_timer #(
   parameter int WIN_LOG2 = 12
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic restart,
   output logic win_end,
   output logic win_tgl
);

   logic [WIN_LOG2-1:0] cnt_q;

   assign win_end = (cnt_q == {WIN_LOG2{1'b1}}) && !restart;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         win_tgl <= 1'b0;
      end else if (restart) begin
         cnt_q   <= '0;
         win_tgl <= ~win_tgl;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (win_end) win_tgl <= ~win_tgl;
      end
   end

   p_window_end_isolated_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      win_end |=> !win_end);

endmodule

// File: rtl/flm_rec_counter.sv
`timescale 1ns/1fs
module flm_rec_counter #(
   parameter int CW          = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic          rec_clk,
   input  logic          rst_n,
   input  logic          win_tgl,
   output logic [CW-1:0] meas_count,
   output logic          done_tgl
);

   logic [SYNC_STAGES:0] tgl_sh;
   logic [CW-1:0]        cnt_q;
   logic                 bnd;

   assign bnd = tgl_sh[SYNC_STAGES] ^ tgl_sh[SYNC_STAGES-1];

   always_ff @(posedge rec_clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_sh     <= '0;
         cnt_q      <= '0;
         meas_count <= '0;
         done_tgl   <= 1'b0;
      end else begin
         tgl_sh <= {tgl_sh[SYNC_STAGES-1:0], win_tgl};
         if (bnd) begin
            meas_count <= cnt_q;
            cnt_q      <= {{(CW-1){1'b0}}, 1'b1};
            done_tgl   <= ~done_tgl;
         end else if (cnt_q != {CW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   p_capture_restarts_count_r2: assert property (@(posedge rec_clk) disable iff (!rst_n)
      bnd |=> (cnt_q == {{(CW-1){1'b0}}, 1'b1}) && (done_tgl != $past(done_tgl)));

endmodule

// File: rtl/flm_lock_fsm.sv
`timescale 1ns/1fs
module flm_lock_fsm
   import flm_pkg::*;
#(
   parameter int WIN_LOG2     = 12,
   parameter int CW           = 18,
   parameter int GOOD_WINDOWS = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic          ref_clk,
   input  logic          rst_n,
   input  logic          carrier_ok,
   input  logic [1:0]    ratio_sel,
   input  logic          win_end,
   input  logic          done_tgl,
   input  logic [CW-1:0] meas_count,
   output logic          restart,
   output logic          locked
);

   localparam int SW = $clog2(GOOD_WINDOWS + 1);

   lock_state_e          state_q;
   logic [SW-1:0]        streak_q;
   logic                 armed_q;
   logic [1:0]           ratio_q;
   logic [SYNC_STAGES-1:0] car_sh;
   logic [SYNC_STAGES:0]   done_sh;
   logic                 car_s;
   logic                 res_pulse;
   logic                 res_take;
   logic [CW-1:0]        exp_cnt;
   logic [CW-1:0]        tol_cnt;
   logic [CW-1:0]        diff_cnt;
   logic                 in_band;

   assign restart   = (ratio_sel != ratio_q);
   assign car_s     = car_sh[SYNC_STAGES-1];
   assign res_pulse = done_sh[SYNC_STAGES] ^ done_sh[SYNC_STAGES-1];
   assign res_take  = res_pulse && armed_q && !restart;
   assign locked    = (state_q == ST_LOCK);

   always_comb begin
      exp_cnt  = {{(CW-RATIO_W){1'b0}}, ratio_of(ratio_q)} << WIN_LOG2;
      tol_cnt  = exp_cnt >> TOL_SHIFT;
      diff_cnt = (meas_count > exp_cnt) ? (meas_count - exp_cnt) : (exp_cnt - meas_count);
      in_band  = (diff_cnt <= tol_cnt);
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_TRAIN;
         streak_q <= '0;
         armed_q  <= 1'b0;
         ratio_q  <= 2'b00;
         car_sh   <= '0;
         done_sh  <= '0;
      end else begin
         ratio_q <= ratio_sel;
         car_sh  <= {car_sh[SYNC_STAGES-2:0], carrier_ok};
         done_sh <= {done_sh[SYNC_STAGES-1:0], done_tgl};
         if (restart) begin
            state_q  <= ST_TRAIN;
            streak_q <= '0;
            armed_q  <= 1'b0;
         end else begin
            if (win_end) armed_q <= 1'b1;
            if (!car_s) begin
               state_q  <= ST_TRAIN;
               streak_q <= '0;
            end else if (res_take) begin
               if (!in_band) begin
                  state_q  <= ST_TRAIN;
                  streak_q <= '0;
               end else if (state_q == ST_TRAIN) begin
                  if (streak_q == SW'(GOOD_WINDOWS - 1)) begin
                     state_q  <= ST_LOCK;
                     streak_q <= '0;
                  end else begin
                     streak_q <= streak_q + 1'b1;
                  end
               end
            end
         end
      end
   end

   p_bad_window_drops_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (res_take && !in_band) |=> !locked);

   p_lock_needs_good_window_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(locked) |-> $past(res_take && in_band && car_s));

   p_carrier_loss_unlocks_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !car_s |=> !locked);

   p_restart_unlocks_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      restart |=> (!locked && !armed_q));

   p_result_stable_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      res_pulse |-> $stable(meas_count));

endmodule

// File: rtl/freq_lock_monitor.sv
`timescale 1ns/1fs
module freq_lock_monitor #(
   parameter int WIN_LOG2     = 12,
   parameter int GOOD_WINDOWS = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       ref_clk,
   input  logic       rec_clk,
   input  logic       rst_n,
   input  logic       carrier_ok,
   input  logic [1:0] ratio_sel,
   output logic       link_ok,
   output logic       train_on_ref,
   output logic       data_gate_low
);

   localparam int CW = WIN_LOG2 + 6;

   generate
      if (WIN_LOG2 < 10 || WIN_LOG2 > 24) begin : g_bad_win
         $error("WIN_LOG2 must lie in 10..24 so the band is at least 8 counts");
      end
      if (GOOD_WINDOWS < 1 || GOOD_WINDOWS > 15) begin : g_bad_good
         $error("GOOD_WINDOWS must lie in 1..15");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 2..4");
      end
   endgenerate

   logic          restart;
   logic          win_end;
   logic          win_tgl;
   logic          done_tgl;
   logic [CW-1:0] meas_count;
   logic          locked;

   flm_window_timer #(.WIN_LOG2(WIN_LOG2)) i_timer (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .restart (restart),
      .win_end (win_end),
      .win_tgl (win_tgl)
   );

   flm_rec_counter #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) i_rec_cnt (
      .rec_clk    (rec_clk),
      .rst_n      (rst_n),
      .win_tgl    (win_tgl),
      .meas_count (meas_count),
      .done_tgl   (done_tgl)
   );

   flm_lock_fsm #(
      .WIN_LOG2     (WIN_LOG2),
      .CW           (CW),
      .GOOD_WINDOWS (GOOD_WINDOWS),
      .SYNC_STAGES  (SYNC_STAGES)
   ) i_fsm (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .carrier_ok (carrier_ok),
      .ratio_sel  (ratio_sel),
      .win_end    (win_end),
      .done_tgl   (done_tgl),
      .meas_count (meas_count),
      .restart    (restart),
      .locked     (locked)
   );

   assign link_ok       = locked && carrier_ok;
   assign train_on_ref  = !link_ok;
   assign data_gate_low = !carrier_ok;

   p_carrier_override_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !carrier_ok |-> (!link_ok && train_on_ref && data_gate_low));

endmodule

// File: tb/test_freq_lock_monitor.sv
`timescale 1ns/1fs
module test_freq_lock_monitor;

   localparam int WL = 10;
   localparam int W  = 1 << WL;

   logic       ref_clk = 1'b0;
   logic       rec_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       carrier_ok = 1'b1;
   logic [1:0] ratio_sel = 2'b00;
   logic       link_ok, train_on_ref, data_gate_low;

   real rec_half = 0.5;
   int  n_run = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   freq_lock_monitor #(.WIN_LOG2(WL)) i_freq_lock_monitor (
      .ref_clk       (ref_clk),
      .rec_clk       (rec_clk),
      .rst_n         (rst_n),
      .carrier_ok    (carrier_ok),
      .ratio_sel     (ratio_sel),
      .link_ok       (link_ok),
      .train_on_ref  (train_on_ref),
      .data_gate_low (data_gate_low)
   );

   always #4 ref_clk = ~ref_clk;
   initial forever begin
      #(rec_half);
      rec_clk = ~rec_clk;
   end

   // vector: {sel[1:0], clock multiplier[4:0], signed ppm[15:0], expected lock}
   localparam int NV = 10;
   localparam logic [23:0] VEC [NV] = '{
      {2'b00, 5'd8,  16'sd0,     1'b1},
      {2'b01, 5'd10, 16'sd0,     1'b1},
      {2'b10, 5'd16, 16'sd0,     1'b1},
      {2'b11, 5'd20, 16'sd0,     1'b1},
      {2'b00, 5'd8,  16'sd500,   1'b1},
      {2'b11, 5'd20, -16'sd500,  1'b1},
      {2'b00, 5'd8,  16'sd3000,  1'b0},
      {2'b10, 5'd16, -16'sd3000, 1'b0},
      {2'b00, 5'd10, 16'sd0,     1'b0},
      {2'b11, 5'd16, 16'sd0,     1'b0}
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic set_clock(input int mult, input int ppm);
      rec_half = (4.0 / mult) * (1.0 + ppm * 1.0e-6);
   endtask

   initial begin
      #(8.0 * 200000);
      if (!finished) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      set_clock(8, 0);
      cyc(3);
      // R8: reset state
      chk(link_ok, 1'b0, "R8", "link_ok in reset");
      chk(train_on_ref, 1'b1, "R8", "train_on_ref in reset");
      rst_n = 1'b1;
      ratio_sel = 2'b11;
      set_clock(20, 0);
      cyc(2 * W + 20);

      for (int v = 0; v < NV; v++) begin
         logic [1:0] sel;
         int mult, ppm;
         logic exp_lock;
         sel      = VEC[v][23:22];
         mult     = int'(VEC[v][21:17]);
         ppm      = int'($signed(VEC[v][16:1]));
         exp_lock = VEC[v][0];
         set_clock(mult, ppm);
         ratio_sel = sel;
         cyc(1);
         chk(link_ok, 1'b0, "R9", "lock after ratio change");
         cyc(2 * W - 4);
         chk(link_ok, 1'b0, "R4", "lock before two good windows");
         cyc(20);
         chk(link_ok, exp_lock, "R1/R2 (R1, R2)", $sformatf("vector %0d lock", v));
         chk(train_on_ref, !exp_lock, "R5", $sformatf("vector %0d train_on_ref", v));
      end

      // R3: frequency step drops lock, then R4 reacquire
      ratio_sel = 2'b00;
      set_clock(8, 0);
      cyc(2 * W + 20);
      chk(link_ok, 1'b1, "R1", "locked before step");
      set_clock(8, 3000);
      cyc(2 * W + 15);
      chk(link_ok, 1'b0, "R3", "lock dropped after step");
      chk(train_on_ref, 1'b1, "R5", "training after drop");
      set_clock(8, 0);
      cyc(3 * W + 15);
      chk(link_ok, 1'b1, "R4", "reacquired after return");

      // R6 / R7: carrier override
      carrier_ok = 1'b0;
      #1;
      chk(link_ok, 1'b0, "R6", "link_ok with carrier low");
      chk(train_on_ref, 1'b1, "R6", "train_on_ref with carrier low");
      chk(data_gate_low, 1'b1, "R6", "data gate with carrier low");
      cyc(100);
      chk(link_ok, 1'b0, "R6", "link_ok held with carrier low");
      carrier_ok = 1'b1;
      cyc(3);
      chk(data_gate_low, 1'b0, "R6", "data gate with carrier high");
      chk(link_ok, 1'b0, "R7", "no instant lock on carrier return");
      cyc(2 * W + 20);
      chk(link_ok, 1'b1, "R7", "lock after carrier return");

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule